// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block sits beside a processor pipeline and handles taking an exception. When the pipeline raises a general exception request, the block updates the architectural exception state. It records the faulting PC in the right save register, writes the cause code and, when supplied, the faulting virtual address. It then sets exception mode and produces a one-cycle redirect carrying the handler address. The handler address is chosen from three vectors: kernel, user or double-exception. The choice depends on the exception-mode and user-mode bits of the status register it holds.

A debug request follows a separate path. It is accepted only while the current interrupt level is below the configured debug level. On acceptance the block saves the PC and the whole status word into per-level debug save registers, raises the interrupt level to the debug level and enters exception mode. Every vector can be moved at run time through a vector-base register. When relocation is enabled, the handler address is the fixed vector minus the reset-time base plus the current base. The pipeline restores the status word and moves the vector base through two write ports.

Top module: `exc_dispatch_unit`

## Requirements
- R1: After reset the status word is 0x00000010 (exception mode set, level 0), the vector base equals its reset value 0x40000000, all save, cause and address registers read zero, and no redirect is issued.
- R2: A general exception routes to the double vector (0x400003C0) when status bit 4 (exception mode) is set. Otherwise it routes to the user vector (0x40000340) when status bit 5 (user mode) is set, or to the kernel vector (0x40000300) when bit 5 is clear.
- R3: A general exception taken with exception mode clear saves its PC into the level-1 saved-PC register.
- R4: A general exception taken with exception mode set saves its PC into the double-exception PC register when that register is configured (the default), and leaves the level-1 saved-PC register unchanged. When the register is not configured, the PC goes into the level-1 saved-PC register.
- R5: Every general exception writes its cause, zero-extended, into the cause register and sets status bit 4. All other status bits keep their values.
- R6: A general exception whose address-valid input is high writes the virtual address into the virtual-address register. When the input is low, that register is unchanged.
- R7: A debug request is accepted only while the status interrupt-level field (bits 3:0) is below the debug level (default 3). A rejected request changes no state, issues no redirect and does not block a general request in the same cycle.
- R8: An accepted debug request writes the debug-cause register, saves the PC into the debug-level saved-PC register and saves the old status word into the debug-level saved-status register. It sets bits 3:0 to the debug level and sets bit 4, leaving the other bits of the status word unchanged. Its target is the debug vector (0x40000280).
- R9: With relocation enabled (the default), every target equals vector − 0x40000000 + current vector base.
- R10: When an accepted debug request and a general request arrive in the same cycle, only the debug entry happens. The cause, saved-PC and virtual-address registers of the general path are unchanged.
- R11: The redirect-valid output is high for exactly the cycle after an accepted request, with the target on the redirect PC. It is low after a cycle with no accepted request.
- R12: The status write port loads the status word in a cycle with no accepted request; in a cycle with an accepted request the dispatch update takes precedence. The vector-base write port loads the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | General exception request strobe |
| exc_pc | input | 32 | Faulting PC (also used by debug entry) |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_vaddr_vld | input | 1 | Exception carries a virtual address |
| exc_vaddr | input | 32 | Faulting virtual address |
| dbg_req | input | 1 | Debug request strobe |
| dbg_cause | input | CAUSE_W | Debug cause code |
| ps_wr_en | input | 1 | Status word write enable |
| ps_wr_data | input | 32 | Status word write value |
| vecbase_wr_en | input | 1 | Vector base write enable |
| vecbase_wr_data | input | 32 | Vector base write value |
| redirect_vld | output | 1 | Redirect strobe |
| redirect_pc | output | 32 | Handler address |
| ps_o | output | 32 | Status word |
| epc1_o | output | 32 | Level-1 saved PC |
| depc_o | output | 32 | Double-exception saved PC (zero if not configured) |
| epc_dbg_o | output | 32 | Debug-level saved PC |
| eps_dbg_o | output | 32 | Debug-level saved status |
| exccause_o | output | 32 | Exception cause register |
| excvaddr_o | output | 32 | Virtual-address register |
| dbgcause_o | output | 32 | Debug cause register |
| vecbase_o | output | 32 | Current vector base |

## Verification
Every result of this block is registered once, so a request driven during one cycle shows up at the next rising edge. The redirect strobe, the handler address and all state registers become visible together. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, half a period after the update. One falling edge later it checks that the redirect strobe has dropped. The write ports follow the same one-edge timing, so each scenario task sets up the status word and the vector base one cycle before it issues the request under test.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

  localparam int unsigned XLEN       = 32;
  localparam int unsigned PS_IL_LSB  = 0;
  localparam int unsigned PS_IL_W    = 4;
  localparam int unsigned PS_EXCM_B  = 4;
  localparam int unsigned PS_UM_B    = 5;

  typedef enum logic [2:0] {
    VK_NONE   = 3'd0,
    VK_KERNEL = 3'd1,
    VK_USER   = 3'd2,
    VK_DOUBLE = 3'd3,
    VK_DEBUG  = 3'd4
  } vec_kind_e;

  // Move a fixed vector by the difference between the live and reset bases.
  function automatic logic [XLEN-1:0] reloc_addr(input logic [XLEN-1:0] vec,
                                                 input logic [XLEN-1:0] rst_base,
                                                 input logic [XLEN-1:0] cur_base);
    return vec - rst_base + cur_base;
  endfunction

  // Status word after debug entry: level field replaced, exception mode set.
  function automatic logic [XLEN-1:0] ps_debug_entry(input logic [XLEN-1:0] ps,
                                                     input logic [PS_IL_W-1:0] lvl);
    logic [XLEN-1:0] r;
    r = ps;
    r[PS_IL_LSB +: PS_IL_W] = lvl;
    r[PS_EXCM_B] = 1'b1;
    return r;
  endfunction

  // Status word after a general exception.
  function automatic logic [XLEN-1:0] ps_general_entry(input logic [XLEN-1:0] ps);
    logic [XLEN-1:0] r;
    r = ps;
    r[PS_EXCM_B] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/exc_route.sv
module exc_route
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned DBG_LEVEL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic               dbg_req,
  input  logic               ps_excm,
  input  logic               ps_um,
  input  logic [PS_IL_W-1:0] ps_intlevel,
  output logic               gen_take,
  output logic               dbg_take,
  output vec_kind_e          kind
);

  localparam logic [PS_IL_W-1:0] DBG_LVL_V = PS_IL_W'(DBG_LEVEL);

  logic dbg_allowed;

  assign dbg_allowed = ps_intlevel < DBG_LVL_V;
  assign dbg_take    = dbg_req && dbg_allowed;
  assign gen_take    = exc_req && !dbg_take;

  always_comb begin
    kind = VK_NONE;
    if (dbg_take)      kind = VK_DEBUG;
    else if (gen_take) begin
      if (ps_excm)     kind = VK_DOUBLE;
      else if (ps_um)  kind = VK_USER;
      else             kind = VK_KERNEL;
    end
  end

  // R10
  one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gen_take, dbg_take}));

  // R10
  dbg_over_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && dbg_take) |-> (kind == VK_DEBUG));

  // R7
  dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && ps_intlevel >= DBG_LVL_V) |-> !dbg_take);

  // R2
  double_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_take && ps_excm) |-> (kind == VK_DOUBLE));

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_dispatch_pkg::*;
#(
  parameter logic [31:0] RESET_VECBASE = 32'h4000_0000,
  parameter logic [31:0] KERNEL_VEC    = 32'h4000_0300,
  parameter logic [31:0] USER_VEC      = 32'h4000_0340,
  parameter logic [31:0] DOUBLE_VEC    = 32'h4000_03C0,
  parameter logic [31:0] DEBUG_VEC     = 32'h4000_0280,
  parameter bit          RELOC_EN      = 1'b1
) (
  input  vec_kind_e        kind,
  input  logic [XLEN-1:0]  vecbase,
  output logic [XLEN-1:0]  target
);

  logic [XLEN-1:0] fixed_vec;

  always_comb begin
    unique case (kind)
      VK_KERNEL: fixed_vec = KERNEL_VEC;
      VK_USER:   fixed_vec = USER_VEC;
      VK_DOUBLE: fixed_vec = DOUBLE_VEC;
      VK_DEBUG:  fixed_vec = DEBUG_VEC;
      default:   fixed_vec = KERNEL_VEC;
    endcase
  end

  generate
    if (RELOC_EN) begin : g_reloc
      assign target = reloc_addr(fixed_vec, RESET_VECBASE, vecbase);
    end else begin : g_fixed
      logic [XLEN-1:0] unused_base;
      assign unused_base = vecbase;
      assign target = fixed_vec;
    end
  endgenerate

endmodule

// File: rtl/exc_dispatch_unit.sv
module exc_dispatch_unit
  import exc_dispatch_pkg::*;
#(
  parameter int unsigned CAUSE_W       = 6,
  parameter int unsigned DBG_LEVEL     = 3,
  parameter bit          HAS_DEPC      = 1'b1,
  parameter bit          RELOC_EN      = 1'b1,
  parameter logic [31:0] PS_RESET      = 32'h0000_0010,
  parameter logic [31:0] RESET_VECBASE = 32'h4000_0000,
  parameter logic [31:0] KERNEL_VEC    = 32'h4000_0300,
  parameter logic [31:0] USER_VEC      = 32'h4000_0340,
  parameter logic [31:0] DOUBLE_VEC    = 32'h4000_03C0,
  parameter logic [31:0] DEBUG_VEC     = 32'h4000_0280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [31:0]        exc_pc,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_vaddr_vld,
  input  logic [31:0]        exc_vaddr,
  input  logic               dbg_req,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic               ps_wr_en,
  input  logic [31:0]        ps_wr_data,
  input  logic               vecbase_wr_en,
  input  logic [31:0]        vecbase_wr_data,
  output logic               redirect_vld,
  output logic [31:0]        redirect_pc,
  output logic [31:0]        ps_o,
  output logic [31:0]        epc1_o,
  output logic [31:0]        depc_o,
  output logic [31:0]        epc_dbg_o,
  output logic [31:0]        eps_dbg_o,
  output logic [31:0]        exccause_o,
  output logic [31:0]        excvaddr_o,
  output logic [31:0]        dbgcause_o,
  output logic [31:0]        vecbase_o
);

  localparam int unsigned PAD_W = XLEN - CAUSE_W;
  localparam logic [PS_IL_W-1:0] DBG_LVL_V = PS_IL_W'(DBG_LEVEL);

  logic [XLEN-1:0] ps_q, epc1_q, depc_q, epcd_q, epsd_q;
  logic [XLEN-1:0] cause_q, vaddr_q, dcause_q, vecbase_q, red_pc_q;
  logic            red_vld_q;

  // named internal events
  logic            gen_take, dbg_take, any_take, is_double, save_to_depc;
  vec_kind_e       kind;
  logic [XLEN-1:0] tgt;

  exc_route #(.DBG_LEVEL(DBG_LEVEL)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .dbg_req     (dbg_req),
    .ps_excm     (ps_q[PS_EXCM_B]),
    .ps_um       (ps_q[PS_UM_B]),
    .ps_intlevel (ps_q[PS_IL_LSB +: PS_IL_W]),
    .gen_take    (gen_take),
    .dbg_take    (dbg_take),
    .kind        (kind)
  );

  exc_target #(
    .RESET_VECBASE (RESET_VECBASE),
    .KERNEL_VEC    (KERNEL_VEC),
    .USER_VEC      (USER_VEC),
    .DOUBLE_VEC    (DOUBLE_VEC),
    .DEBUG_VEC     (DEBUG_VEC),
    .RELOC_EN      (RELOC_EN)
  ) u_target (
    .kind    (kind),
    .vecbase (vecbase_q),
    .target  (tgt)
  );

  assign any_take     = gen_take || dbg_take;
  assign is_double    = gen_take && ps_q[PS_EXCM_B];
  assign save_to_depc = is_double && HAS_DEPC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_q      <= PS_RESET;
      vecbase_q <= RESET_VECBASE;
      epc1_q    <= '0;
      depc_q    <= '0;
      epcd_q    <= '0;
      epsd_q    <= '0;
      cause_q   <= '0;
      vaddr_q   <= '0;
      dcause_q  <= '0;
      red_vld_q <= 1'b0;
      red_pc_q  <= '0;
    end else begin
      red_vld_q <= any_take;
      if (any_take) red_pc_q <= tgt;
      if (vecbase_wr_en) vecbase_q <= vecbase_wr_data;
      if (dbg_take) begin
        dcause_q <= {{PAD_W{1'b0}}, dbg_cause};
        epcd_q   <= exc_pc;
        epsd_q   <= ps_q;
        ps_q     <= ps_debug_entry(ps_q, DBG_LVL_V);
      end else if (gen_take) begin
        if (exc_vaddr_vld) vaddr_q <= exc_vaddr;
        cause_q <= {{PAD_W{1'b0}}, exc_cause};
        ps_q    <= ps_general_entry(ps_q);
        if (save_to_depc) depc_q <= exc_pc;
        else              epc1_q <= exc_pc;
      end else if (ps_wr_en) begin
        ps_q <= ps_wr_data;
      end
    end
  end

  assign redirect_vld = red_vld_q;
  assign redirect_pc  = red_pc_q;
  assign ps_o         = ps_q;
  assign epc1_o       = epc1_q;
  assign depc_o       = HAS_DEPC ? depc_q : '0;
  assign epc_dbg_o    = epcd_q;
  assign eps_dbg_o    = epsd_q;
  assign exccause_o   = cause_q;
  assign excvaddr_o   = vaddr_q;
  assign dbgcause_o   = dcause_q;
  assign vecbase_o    = vecbase_q;

  // R5
  excm_after_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_take |=> ps_o[PS_EXCM_B]);

  // R4
  depc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_to_depc |=> (depc_o == $past(exc_pc)) && $stable(epc1_o));

  // R8
  dbg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> (ps_o[PS_IL_LSB +: PS_IL_W] == DBG_LVL_V) && ps_o[PS_EXCM_B]
                 && (eps_dbg_o == $past(ps_o)));

  // R11
  redirect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req || dbg_req) |=> !redirect_vld);

  // R10
  dbg_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> $stable(exccause_o) && $stable(epc1_o));

endmodule

// File: tb/exc_dispatch_unit_tb.sv
module exc_dispatch_unit_tb_top;

  localparam int unsigned CW = 6;
  localparam logic [31:0] RB  = 32'h4000_0000;
  localparam logic [31:0] VK  = 32'h4000_0300;
  localparam logic [31:0] VU  = 32'h4000_0340;
  localparam logic [31:0] VD  = 32'h4000_03C0;
  localparam logic [31:0] VG  = 32'h4000_0280;
  localparam int unsigned DLV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_req = 1'b0, exc_vaddr_vld = 1'b0, dbg_req = 1'b0;
  logic ps_wr_en = 1'b0, vecbase_wr_en = 1'b0;
  logic [31:0] exc_pc = '0, exc_vaddr = '0, ps_wr_data = '0, vecbase_wr_data = '0;
  logic [CW-1:0] exc_cause = '0, dbg_cause = '0;
  logic redirect_vld;
  logic [31:0] redirect_pc, ps_o, epc1_o, depc_o, epc_dbg_o, eps_dbg_o;
  logic [31:0] exccause_o, excvaddr_o, dbgcause_o, vecbase_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] cur_base = 32'h4000_0000;

  always #10 clk = ~clk;

  exc_dispatch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_pc(exc_pc),
    .exc_cause(exc_cause), .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr),
    .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
    .ps_wr_data(ps_wr_data), .vecbase_wr_en(vecbase_wr_en),
    .vecbase_wr_data(vecbase_wr_data), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc), .ps_o(ps_o), .epc1_o(epc1_o), .depc_o(depc_o),
    .epc_dbg_o(epc_dbg_o), .eps_dbg_o(eps_dbg_o), .exccause_o(exccause_o),
    .excvaddr_o(excvaddr_o), .dbgcause_o(dbgcause_o), .vecbase_o(vecbase_o)
  );

  // handler address as the bench sees it
  function automatic logic [31:0] exp_tgt(input logic [31:0] v);
    return cur_base + (v - RB);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_ps(input logic [31:0] v);
    ps_wr_en = 1'b1; ps_wr_data = v;
    @(negedge clk);
    ps_wr_en = 1'b0;
  endtask

  task automatic write_base(input logic [31:0] v);
    vecbase_wr_en = 1'b1; vecbase_wr_data = v;
    @(negedge clk);
    vecbase_wr_en = 1'b0;
    cur_base = v;
    chk("R12", "vecbase", vecbase_o, v);
  endtask

  // drive one request cycle; outputs are read at the following falling edge
  task automatic fire(input bit g, input bit d, input logic [31:0] pc,
                      input logic [CW-1:0] gc, input logic [CW-1:0] dc,
                      input bit vv, input logic [31:0] va);
    exc_req = g; dbg_req = d; exc_pc = pc; exc_cause = gc; dbg_cause = dc;
    exc_vaddr_vld = vv; exc_vaddr = va;
    @(negedge clk);
    exc_req = 1'b0; dbg_req = 1'b0; exc_vaddr_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ps", ps_o, 32'h10);
    chk("R1", "vecbase", vecbase_o, RB);
    chk("R1", "redirect_vld", {31'b0, redirect_vld}, 32'h0);
    chk("R1", "epc1", epc1_o, 32'h0);
    chk("R1", "cause", exccause_o, 32'h0);
  endtask

  task automatic t_kernel();
    write_ps(32'h0000_0000);
    fire(1, 0, 32'h0000_1000, 6'd5, 6'd0, 1, 32'hDEAD_0000);
    chk("R11", "redirect_vld", {31'b0, redirect_vld}, 32'h1);
    chk("R2", "kernel target", redirect_pc, exp_tgt(VK));
    chk("R3", "epc1", epc1_o, 32'h0000_1000);
    chk("R5", "cause", exccause_o, 32'd5);
    chk("R5", "ps", ps_o, 32'h10);
    chk("R6", "vaddr", excvaddr_o, 32'hDEAD_0000);
    @(negedge clk);
    chk("R11", "redirect drop", {31'b0, redirect_vld}, 32'h0);
  endtask

  task automatic t_user();
    write_ps(32'h0000_0122);
    fire(1, 0, 32'h0000_1400, 6'd63, 6'd0, 0, 32'h1111_1111);
    chk("R2", "user target", redirect_pc, exp_tgt(VU));
    chk("R3", "epc1", epc1_o, 32'h0000_1400);
    chk("R5", "ps keeps other bits", ps_o, 32'h0000_0132);
    chk("R5", "cause zero-ext", exccause_o, 32'd63);
    chk("R6", "vaddr unchanged", excvaddr_o, 32'hDEAD_0000);
  endtask

  task automatic t_double();
    // exception mode is still set from the previous entry
    fire(1, 0, 32'h0000_2000, 6'd9, 6'd0, 0, 32'h0);
    chk("R2", "double target", redirect_pc, exp_tgt(VD));
    chk("R4", "depc", depc_o, 32'h0000_2000);
    chk("R4", "epc1 unchanged", epc1_o, 32'h0000_1400);
    chk("R5", "cause", exccause_o, 32'd9);
  endtask

  task automatic t_reloc();
    write_base(32'h8000_1000);
    write_ps(32'h0000_0000);
    fire(1, 0, 32'h0000_3000, 6'd1, 6'd0, 0, 32'h0);
    chk("R9", "relocated kernel", redirect_pc, 32'h8000_1300);
    fire(1, 0, 32'h0000_3004, 6'd2, 6'd0, 0, 32'h0);
    chk("R9", "relocated double", redirect_pc, 32'h8000_13C0);
    write_base(RB);
  endtask

  task automatic t_debug_ok();
    write_ps(32'h0000_0021);
    fire(0, 1, 32'h0000_4000, 6'd0, 6'd2, 0, 32'h0);
    chk("R8", "debug target", redirect_pc, exp_tgt(VG));
    chk("R8", "dbgcause", dbgcause_o, 32'd2);
    chk("R8", "epc_dbg", epc_dbg_o, 32'h0000_4000);
    chk("R8", "eps_dbg", eps_dbg_o, 32'h0000_0021);
    chk("R8", "ps", ps_o, 32'h0000_0030 | DLV);
  endtask

  task automatic t_debug_reject();
    write_ps(32'h0000_0003);
    fire(0, 1, 32'h0000_5000, 6'd0, 6'd7, 0, 32'h0);
    chk("R7", "no redirect", {31'b0, redirect_vld}, 32'h0);
    chk("R7", "dbgcause unchanged", dbgcause_o, 32'd2);
    chk("R7", "ps unchanged", ps_o, 32'h0000_0003);
    chk("R7", "epc_dbg unchanged", epc_dbg_o, 32'h0000_4000);
    // rejected debug with a general request: general proceeds
    fire(1, 1, 32'h0000_5100, 6'd11, 6'd7, 0, 32'h0);
    chk("R7", "general proceeds", redirect_pc, exp_tgt(VK));
    chk("R7", "cause", exccause_o, 32'd11);
    chk("R7", "dbgcause still", dbgcause_o, 32'd2);
  endtask

  task automatic t_both();
    write_ps(32'h0000_0000);
    fire(1, 1, 32'h0000_6000, 6'd20, 6'd4, 1, 32'hBEEF_0000);
    chk("R10", "debug wins target", redirect_pc, exp_tgt(VG));
    chk("R10", "cause unchanged", exccause_o, 32'd11);
    chk("R10", "epc1 unchanged", epc1_o, 32'h0000_5100);
    chk("R10", "vaddr unchanged", excvaddr_o, 32'hDEAD_0000);
    chk("R10", "dbgcause", dbgcause_o, 32'd4);
  endtask

  task automatic t_ps_override();
    write_ps(32'h0000_0000);
    chk("R12", "ps write", ps_o, 32'h0);
    ps_wr_en = 1'b1; ps_wr_data = 32'h0000_0F2F;
    fire(1, 0, 32'h0000_7000, 6'd3, 6'd0, 0, 32'h0);
    ps_wr_en = 1'b0;
    chk("R12", "dispatch beats write", ps_o, 32'h10);
    chk("R12", "kernel target", redirect_pc, exp_tgt(VK));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_kernel();
    t_user();
    t_double();
    t_reloc();
    t_debug_ok();
    t_debug_reject();
    t_both();
    t_ps_override();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule